// File: doc/BRIEF.md
# External Bus Request/Grant Controller

This block decides when a processor hands its external memory bus to another bus master. An outside device asks for the bus by pulling an active-low request line low. That line is not timed to the processor clock. The block brings the request into the clock domain. It then lets any external access already in flight finish, or any boot byte being loaded finish. After that it asserts an active-low grant and puts the address, data and strobe drivers into high impedance.

While the request is pending or granted, the block also tells the core when to stall. If go mode is off, the core stops as soon as the request is recognized and stays stopped until the request is withdrawn. If go mode is on, the core keeps running from internal memory. It stops only when its next instruction needs the external bus. This same stall is what holds back the second external access of an instruction when the grant lands between its two accesses. When the processor is in reset, the grant follows the recognized request with no delay.

The block changes no processor state other than this stall indication. Serial and host ports are not affected.

Top module: `busgrant_ctrl`

## Requirements
- R1: The request is recognized two clock edges after `bus_req_n` falls (two synchronizer stages). With no access in flight, no boot and no processor reset, `bus_grant_n` goes low, and `drv_off` goes high, in the cycle after recognition.
- R2: When an access is in flight (`acc_busy`=1, `acc_done`=0) at recognition, the grant stays high until `acc_done` is seen high. It goes low in the cycle after that `acc_done` cycle.
- R3: While a recognized request is pending or granted, `core_halt` stays high with go mode off. This keeps the second access of an instruction back until the request is removed.
- R4: With go mode off, `core_halt` rises in the recognition cycle, which is before the grant. It stays high for the whole grant.
- R5: With go mode on and a request recognized, `core_halt` equals `ext_need`. The core runs on while no external access is needed.
- R6: In the cycle where the removal of the request is recognized, `bus_grant_n` returns high, `drv_off` returns low and `core_halt` returns low.
- R7: While `cpu_rst` is high, `bus_grant_n` goes low in the same cycle the request is recognized.
- R8: While `boot_active` is high, the grant is given in the cycle after `boot_byte_done` is seen high. If `boot_byte_done` is high in the recognition cycle itself, the grant is given in the next cycle.
- R9: Out of `rst_n`, `bus_grant_n` is high and `drv_off` and `core_halt` are low.
- R10: A request removed while the block is still waiting on an access produces no grant. A later `acc_done` pulse does not grant either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Power-up reset of this block, active low |
| bus_req_n | input | 1 | Bus request from an external master, active low, asynchronous |
| cpu_rst | input | 1 | Processor reset is active |
| boot_active | input | 1 | Boot loading is in progress |
| go_en | input | 1 | Go mode: the core may run from internal memory during a grant |
| acc_busy | input | 1 | An external access is in progress |
| acc_done | input | 1 | The current external access completes in this cycle |
| boot_byte_done | input | 1 | The current boot byte, including its wait states, completes in this cycle |
| ext_need | input | 1 | The next instruction needs the external bus |
| bus_grant_n | output | 1 | Bus grant, active low |
| drv_off | output | 1 | Puts the address, data and strobe drivers in high impedance |
| core_halt | output | 1 | Stalls the core |

## Verification
The request is applied in several settings. The first is an idle bus, which fixes the three-edge grant latency. The next is an access in flight with a delayed completion pulse, which separates waiting on `acc_done` from granting at once. A request is also withdrawn during that wait, which shows that a late completion cannot grant. The request is also applied under processor reset, where the grant comes one cycle earlier than in the idle case. It is applied during boot, with the byte-done pulse both late and coincident with recognition. During a grant the bench sweeps all four combinations of `go_en` and `ext_need`, and checks the stall against `!go_en || ext_need`.

// File: rtl/brg_pkg.sv
package brg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_WAIT_ACC  = 2'd1,
      ST_WAIT_BOOT = 2'd2,
      ST_GRANT     = 2'd3
   } brg_state_e;
endpackage

// File: rtl/brg_sync.sv
module brg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_o
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $fatal(1, "brg_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= ~async_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[LAST];
endmodule

// File: rtl/brg_fsm.sv
module brg_fsm
   import brg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       cpu_rst,
   input  logic       boot_active,
   input  logic       acc_busy,
   input  logic       acc_done,
   input  logic       boot_byte_done,
   output brg_state_e state_o
);
   brg_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (cpu_rst && req_s) begin
         state_d = ST_GRANT;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_s) begin
                  if (boot_active)
                     state_d = boot_byte_done ? ST_GRANT : ST_WAIT_BOOT;
                  else if (acc_busy && !acc_done)
                     state_d = ST_WAIT_ACC;
                  else
                     state_d = ST_GRANT;
               end
            end
            ST_WAIT_ACC: begin
               if (!req_s)        state_d = ST_IDLE;
               else if (acc_done) state_d = ST_GRANT;
            end
            ST_WAIT_BOOT: begin
               if (!req_s)                             state_d = ST_IDLE;
               else if (boot_byte_done || !boot_active) state_d = ST_GRANT;
            end
            ST_GRANT: begin
               if (!req_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R10: a withdrawn request never leads to a grant state
   a_r10_no_grant_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_s && state_q != ST_GRANT) |=> (state_q != ST_GRANT));

   // R8: while a boot byte is loading, no grant state is entered
   a_r8_boot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_BOOT && boot_active && !boot_byte_done && !cpu_rst)
      |=> (state_q != ST_GRANT));
endmodule

// File: rtl/brg_drive.sv
module brg_drive
   import brg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  brg_state_e state_i,
   input  logic       req_s,
   input  logic       cpu_rst,
   input  logic       go_en,
   input  logic       ext_need,
   output logic       bus_grant_n,
   output logic       drv_off,
   output logic       core_halt
);
   logic granted;

   always_comb begin
      granted     = req_s && ((state_i == ST_GRANT) || cpu_rst);
      bus_grant_n = ~granted;
      drv_off     = granted;
      core_halt   = req_s && (!go_en || ext_need);
   end

   // R4: without go mode the core is stalled whenever the bus is given away
   a_r4_halt_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_grant_n && !go_en) |-> core_halt);

   // R6: removal of the request ends the grant in the same cycle
   a_r6_release_now: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_s) |-> (bus_grant_n && !drv_off && !core_halt));
endmodule

// File: rtl/busgrant_ctrl.sv
module busgrant_ctrl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req_n,
   input  logic cpu_rst,
   input  logic boot_active,
   input  logic go_en,
   input  logic acc_busy,
   input  logic acc_done,
   input  logic boot_byte_done,
   input  logic ext_need,
   output logic bus_grant_n,
   output logic drv_off,
   output logic core_halt
);
   import brg_pkg::*;

   logic       req_s;
   brg_state_e state;

   brg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (bus_req_n),
      .sync_o  (req_s)
   );

   brg_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_s          (req_s),
      .cpu_rst        (cpu_rst),
      .boot_active    (boot_active),
      .acc_busy       (acc_busy),
      .acc_done       (acc_done),
      .boot_byte_done (boot_byte_done),
      .state_o        (state)
   );

   brg_drive u_drive (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .req_s       (req_s),
      .cpu_rst     (cpu_rst),
      .go_en       (go_en),
      .ext_need    (ext_need),
      .bus_grant_n (bus_grant_n),
      .drv_off     (drv_off),
      .core_halt   (core_halt)
   );

   // R7: under processor reset the grant follows recognition at once
   a_r7_reset_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rst && req_s) |-> !bus_grant_n);

   // R2: an unfinished access blocks the grant in the next cycle
   a_r2_wait_access: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant_n && req_s && acc_busy && !acc_done && !boot_active && !cpu_rst)
      |=> (bus_grant_n || cpu_rst));

   // R1: the drivers are released exactly while the grant is low
   a_r1_drivers_follow: assert property (@(posedge clk) disable iff (!rst_n)
      drv_off == !bus_grant_n);
endmodule

// File: tb/busgrant_ctrl_tb.sv
module busgrant_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req_n = 1'b1;
   logic cpu_rst = 1'b0, boot_active = 1'b0, go_en = 1'b0;
   logic acc_busy = 1'b0, acc_done = 1'b0, boot_byte_done = 1'b0, ext_need = 1'b0;
   logic bus_grant_n, drv_off, core_halt;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   busgrant_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .cpu_rst(cpu_rst),
      .boot_active(boot_active), .go_en(go_en), .acc_busy(acc_busy),
      .acc_done(acc_done), .boot_byte_done(boot_byte_done), .ext_need(ext_need),
      .bus_grant_n(bus_grant_n), .drv_off(drv_off), .core_halt(core_halt)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic nx();
      @(negedge clk);
   endtask

   task automatic release_req();
      bus_req_n = 1'b1;
      nx();
      nx();
      chk("R6 grant_n after release", bus_grant_n, 1'b1);
      chk("R6 drv_off after release", drv_off, 1'b0);
      chk("R6 halt after release", core_halt, 1'b0);
      nx();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      nx();
      nx();
      chk("R9 grant_n in reset", bus_grant_n, 1'b1);
      chk("R9 drv_off in reset", drv_off, 1'b0);
      chk("R9 halt in reset", core_halt, 1'b0);
      rst_n = 1'b1;
      nx();
      chk("R9 grant_n after reset", bus_grant_n, 1'b1);

      // R1 / R4: idle bus, go mode off
      bus_req_n = 1'b0;
      nx();
      chk("R1 no grant before recognition", bus_grant_n, 1'b1);
      nx();
      chk("R1 no grant in recognition cycle", bus_grant_n, 1'b1);
      chk("R4 halt in recognition cycle", core_halt, 1'b1);
      nx();
      chk("R1 grant next cycle", bus_grant_n, 1'b0);
      chk("R1 drivers off", drv_off, 1'b1);
      chk("R4 halt during grant", core_halt, 1'b1);
      release_req();

      // R2 / R3: access in flight, grant between two accesses
      acc_busy = 1'b1;
      bus_req_n = 1'b0;
      nx();
      nx();
      for (int k = 0; k < 3; k++) begin
         nx();
         chk("R2 grant held during access", bus_grant_n, 1'b1);
         chk("R3 second access held back", core_halt, 1'b1);
      end
      acc_done = 1'b1;
      nx();
      acc_done = 1'b0;
      acc_busy = 1'b0;
      chk("R2 grant cycle after done", bus_grant_n, 1'b0);
      chk("R3 halt while granted", core_halt, 1'b1);
      nx();
      chk("R3 halt held until release", core_halt, 1'b1);
      release_req();

      // R10: request withdrawn while waiting on an access
      acc_busy = 1'b1;
      bus_req_n = 1'b0;
      nx();
      nx();
      bus_req_n = 1'b1;
      nx();
      nx();
      nx();
      acc_done = 1'b1;
      nx();
      acc_done = 1'b0;
      acc_busy = 1'b0;
      for (int k = 0; k < 3; k++) begin
         nx();
         chk("R10 no grant after withdrawal", bus_grant_n, 1'b1);
      end

      // R5: sweep of go_en x ext_need during a grant
      bus_req_n = 1'b0;
      nx();
      nx();
      nx();
      for (int g = 0; g < 2; g++) begin
         for (int e = 0; e < 2; e++) begin
            go_en = g[0];
            ext_need = e[0];
            #1;
            chk("R5 halt vs go/ext", core_halt, (!g[0]) || e[0]);
            chk("R5 grant kept", bus_grant_n, 1'b0);
         end
      end
      go_en = 1'b1;
      ext_need = 1'b0;
      release_req();
      go_en = 1'b0;

      // R7: processor reset active
      cpu_rst = 1'b1;
      acc_busy = 1'b1;
      bus_req_n = 1'b0;
      nx();
      chk("R7 no grant before recognition", bus_grant_n, 1'b1);
      nx();
      chk("R7 grant in recognition cycle", bus_grant_n, 1'b0);
      release_req();
      cpu_rst = 1'b0;
      acc_busy = 1'b0;

      // R8: boot, late byte completion
      boot_active = 1'b1;
      bus_req_n = 1'b0;
      nx();
      nx();
      nx();
      chk("R8 grant held during byte", bus_grant_n, 1'b1);
      nx();
      chk("R8 grant held during byte", bus_grant_n, 1'b1);
      boot_byte_done = 1'b1;
      nx();
      boot_byte_done = 1'b0;
      chk("R8 grant cycle after byte done", bus_grant_n, 1'b0);
      release_req();

      // R8: byte completion coincides with recognition
      bus_req_n = 1'b0;
      nx();
      nx();
      boot_byte_done = 1'b1;
      nx();
      boot_byte_done = 1'b0;
      chk("R8 grant after coincident byte done", bus_grant_n, 1'b0);
      release_req();
      boot_active = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule